// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets a clocked system use an external asynchronous static RAM of 128K words by 16 bits. A client hands it one access at a time over a valid/ready request port: an address, write data, a read/write flag and one enable bit per byte lane. The controller then plays out the strobe sequence the memory expects and finishes with a one-cycle done pulse. For a read, the captured data arrives on the same cycle as the done pulse.

The memory side has active-low chip, output and write strobes and one active-low strobe per byte lane. It also has the address and a data bus split into an outgoing word, an incoming word and a drive enable for the pad buffers. Every memory timing figure is given in nanoseconds as a parameter, together with the clock period. The controller rounds each figure up to whole clock cycles. All strobes come straight from flip-flops, so they cannot glitch. Writes happen only while chip select and write strobe are both low. The address never moves while that window is open. Each read is followed by a bus-release gap, so the controller and the memory never drive the data wires at the same time.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, and whenever no access is in progress, the chip, output and write strobes and both lane strobes are high, the drive enable and done are low, and ready is high.
- R2: A write keeps chip select and the strobes of the enabled lanes low for PULSE+2 cycles. The write strobe goes low one cycle after chip select falls, stays low for PULSE cycles and rises one cycle before chip select rises. PULSE is the larger of ceil(T_WP_NS/CLK_NS) and ceil(T_WC_NS/CLK_NS)-2.
- R3: The address is held constant for as long as chip select is low, and so is the outgoing data word during a write.
- R4: The data drive enable is high only during the write-strobe-low cycles and the one cycle after them. It is never high while the output strobe is low.
- R5: A read keeps chip select, the output strobe and the enabled lane strobes low for RD = ceil(T_ACC_NS/CLK_NS) cycles with the write strobe high. The incoming word is sampled at the end of the last of those cycles.
- R6: Done is a single-cycle pulse. After a write it is high in the cycle in which chip select has just risen. After a read it is high together with the new read data, in the first cycle after the read strobes rise.
- R7: Lane bit 0 selects data bits 7:0 through lane strobe bit 0, and lane bit 1 selects bits 15:8 through lane strobe bit 1. In the read result, the bytes of lanes that were not enabled read as zero.
- R8: After a read, ready stays low for TURN = ceil(T_TURN_NS/CLK_NS) cycles after the output strobe rises. The drive enable therefore rises no sooner than TURN cycles after the output strobe has risen.
- R9: A request is taken only on a clock edge where both valid and ready are high. Ready is low from that edge until the access has finished, and request inputs presented while ready is low have no effect.
- R10: A request with both lane bits clear runs the normal sequence with both lane strobes held high. It leaves the memory contents unchanged, and as a read it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte lane enables, bit 0 = bits 7:0 |
| rsp_done | output | 1 | Access finished (one cycle) |
| rsp_rdata | output | 16 | Read data, valid with done after a read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_bsel_n | output | 2 | Lane strobes, active low, bit 0 = bits 7:0 |
| mem_addr | output | 17 | Memory address |
| mem_dout | output | 16 | Data toward the memory |
| mem_din | input | 16 | Data from the memory |
| mem_dout_en | output | 1 | Drive enable for the data pad buffers |

## Verification
The assertions assume that reset is held for at least one clock edge before any traffic starts. They also assume that request inputs change only between clock edges. The bench drives every input on the falling clock edge, and it releases reset long before the first request. The memory model in the bench puts a fixed filler byte on lanes that were not enabled, so a missing read mask becomes visible. Requests are sometimes raised while the controller is busy, with the data inputs changing cycle by cycle, to show that such inputs are ignored.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RTURN
    } ctrl_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // High in the last cycle of the interval that was loaded.
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe #(
    parameter int unsigned LANES = 2
) (
    input  logic             en,
    input  logic [LANES-1:0] lanes,
    output logic [LANES-1:0] strobe_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strobe_n[i] = !(en && lanes[i]);
    end
endmodule

// File: rtl/sram_read_mask.sv
module sram_read_mask #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES-1:0]        sel_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = sel_n[i] ? '0 : din[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned LANES     = 2,
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned T_ACC_NS  = 70,
    parameter int unsigned T_WP_NS   = 50,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_TURN_NS = 25
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_lanes,
    output logic                     rsp_done,
    output logic [LANES*LANE_W-1:0]  rsp_rdata,
    output logic                     mem_ce_n,
    output logic                     mem_oe_n,
    output logic                     mem_we_n,
    output logic [LANES-1:0]         mem_bsel_n,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [LANES*LANE_W-1:0]  mem_dout,
    input  logic [LANES*LANE_W-1:0]  mem_din,
    output logic                     mem_dout_en
);
    localparam int unsigned DATA_W   = LANES * LANE_W;
    localparam int unsigned WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
    // Setup and hold cycles surround the pulse; stretch it to fill the cycle time.
    localparam int unsigned PULSE    = (WC_CYC > WP_CYC + 2) ? (WC_CYC - 2) : WP_CYC;
    localparam int unsigned RD_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = (PULSE > RD_CYC) ? ((PULSE > TURN_CYC) ? PULSE : TURN_CYC)
                                                         : ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC);
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  bsel_n;
        logic              dout_en;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st:      ST_IDLE,
        addr:    '0,
        wdata:   '0,
        ce_n:    1'b1,
        oe_n:    1'b1,
        we_n:    1'b1,
        bsel_n:  '1,
        dout_en: 1'b0,
        done:    1'b0,
        rdata:   '0
    };

    regs_t             r_d, r_q;
    logic              t_load;
    logic [CW-1:0]     t_val;
    logic              t_expired;
    logic [LANES-1:0]  new_bsel_n;
    logic [DATA_W-1:0] masked_din;

    sram_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    sram_lane_strobe #(.LANES(LANES)) u_strobe (
        .en       (req_valid),
        .lanes    (req_lanes),
        .strobe_n (new_bsel_n)
    );

    sram_read_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
        .sel_n (r_q.bsel_n),
        .din   (mem_din),
        .dout  (masked_din)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        t_load = 1'b0;
        t_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr   = req_addr;
                    r_d.wdata  = req_wdata;
                    r_d.ce_n   = 1'b0;
                    r_d.bsel_n = new_bsel_n;
                    t_load     = 1'b1;
                    if (req_write) begin
                        r_d.st = ST_WSETUP;
                        t_val  = '0;
                    end else begin
                        r_d.st   = ST_RACC;
                        r_d.oe_n = 1'b0;
                        t_val    = CW'(RD_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                if (t_expired) begin
                    r_d.st      = ST_WPULSE;
                    r_d.we_n    = 1'b0;
                    r_d.dout_en = 1'b1;
                    t_load      = 1'b1;
                    t_val       = CW'(PULSE - 1);
                end
            end
            ST_WPULSE: begin
                if (t_expired) begin
                    r_d.st   = ST_WHOLD;
                    r_d.we_n = 1'b1;
                    t_load   = 1'b1;
                    t_val    = '0;
                end
            end
            ST_WHOLD: begin
                if (t_expired) begin
                    r_d.st      = ST_IDLE;
                    r_d.ce_n    = 1'b1;
                    r_d.bsel_n  = '1;
                    r_d.dout_en = 1'b0;
                    r_d.done    = 1'b1;
                end
            end
            ST_RACC: begin
                if (t_expired) begin
                    r_d.rdata  = masked_din;
                    r_d.done   = 1'b1;
                    r_d.st     = ST_RTURN;
                    r_d.ce_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.bsel_n = '1;
                    t_load     = 1'b1;
                    t_val      = CW'(TURN_CYC - 1);
                end
            end
            ST_RTURN: begin
                if (t_expired)
                    r_d.st = ST_IDLE;
            end
            default: r_d = RST_VAL;
        endcase
        // The pad drive never overlaps the memory's own output window.
        if (!r_d.oe_n)
            r_d.dout_en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= RST_VAL;
        else
            r_q <= r_d;
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_done    = r_q.done;
    assign rsp_rdata   = r_q.rdata;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_we_n    = r_q.we_n;
    assign mem_bsel_n  = r_q.bsel_n;
    assign mem_addr    = r_q.addr;
    assign mem_dout    = r_q.wdata;
    assign mem_dout_en = r_q.dout_en;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LANES    = 2,
    parameter int unsigned TURN_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_bsel_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    localparam int unsigned GW = $clog2(TURN_CYC + 2);
    localparam logic [GW-1:0] GAP_SAT = GW'(TURN_CYC + 1);

    // Cycles since the output strobe was last low, saturating.
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= GAP_SAT;
        else if (!mem_oe_n)
            gap_q <= '0;
        else if (gap_q != GAP_SAT)
            gap_q <= gap_q + 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && (&mem_bsel_n) && !mem_dout_en));

    assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    assert_we_after_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en);

    assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (!mem_we_n || $past(!mem_we_n)));

    assert_read_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_turn_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (gap_q >= GW'(TURN_CYC)));

    assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANES    (LANES),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_bsel_n  (mem_bsel_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_ACC  = 70;
    localparam int T_WP   = 50;
    localparam int T_WC   = 70;
    localparam int T_TURN = 25;
    localparam int WP_C   = (T_WP + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WC_C   = (T_WC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int PULSE  = (WC_C - 2 > WP_C) ? WC_C - 2 : WP_C;
    localparam int RD     = (T_ACC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TURN   = (T_TURN + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic        req_write = 0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [1:0]  mem_bsel_n;
    logic [16:0] mem_addr;
    logic [15:0] mem_dout;
    logic [15:0] mem_din;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bsel_n(mem_bsel_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory model: small array, filler byte on lanes that are not enabled.
    logic [15:0] sram [1024];
    initial for (int i = 0; i < 1024; i++) sram[i] = '0;

    always_comb begin
        mem_din = 16'hA5A5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_bsel_n[0]) mem_din[7:0]  = sram[mem_addr[9:0]][7:0];
            if (!mem_bsel_n[1]) mem_din[15:8] = sram[mem_addr[9:0]][15:8];
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_dout_en) begin
            if (!mem_bsel_n[0]) sram[mem_addr[9:0]][7:0]  = mem_dout[7:0];
            if (!mem_bsel_n[1]) sram[mem_addr[9:0]][15:8] = mem_dout[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle, 1 setup, 2 write low, 3 hold, 4 read, 5 release gap.
    int          ph = 0;
    int          cnt = 0;
    bit          e_done = 0;
    logic [15:0] e_rdata = '0;
    bit          m_write = 0;
    logic [16:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic [1:0]  m_lanes = '0;
    logic [15:0] shadow [int];

    function automatic logic [15:0] shadow_rd(input logic [16:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; e_done = 0; e_rdata = '0;
        end else begin
            e_done = 0;
            case (ph)
                0: if (req_valid) begin
                    m_write = req_write; m_addr = req_addr;
                    m_data = req_wdata; m_lanes = req_lanes;
                    if (req_write) begin ph = 1; cnt = 1; end
                    else begin ph = 4; cnt = RD; end
                end
                1: begin cnt--; if (cnt == 0) begin ph = 2; cnt = PULSE; end end
                2: begin cnt--; if (cnt == 0) begin ph = 3; cnt = 1; end end
                3: begin
                    cnt--;
                    if (cnt == 0) begin
                        logic [15:0] w;
                        w = shadow_rd(m_addr);
                        if (m_lanes[0]) w[7:0]  = m_data[7:0];
                        if (m_lanes[1]) w[15:8] = m_data[15:8];
                        shadow[int'(m_addr)] = w;
                        e_done = 1; ph = 0;
                    end
                end
                4: begin
                    cnt--;
                    if (cnt == 0) begin
                        logic [15:0] r;
                        r = shadow_rd(m_addr);
                        e_rdata = {m_lanes[1] ? r[15:8] : 8'h00, m_lanes[0] ? r[7:0] : 8'h00};
                        e_done = 1; ph = 5; cnt = TURN;
                    end
                end
                default: begin cnt--; if (cnt == 0) ph = 0; end
            endcase
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit          act;
            logic [1:0]  e_bsel;
            string       ce_tag;
            act = (ph >= 1 && ph <= 4);
            ce_tag = (ph == 0 || ph == 5) ? "R1 idle strobes" : (m_write ? "R2 write chip select" : "R5 read chip select");
            chk(mem_ce_n == !act, ce_tag, 32'(mem_ce_n), 32'(!act));
            chk(mem_we_n == !(ph == 2), "R2 write strobe", 32'(mem_we_n), 32'(!(ph == 2)));
            chk(mem_oe_n == !(ph == 4), "R5 output strobe", 32'(mem_oe_n), 32'(!(ph == 4)));
            e_bsel = act ? ~m_lanes : 2'b11;
            chk(mem_bsel_n == e_bsel, (m_lanes == 2'b00) ? "R10 lane strobes" : "R7 lane strobes",
                32'(mem_bsel_n), 32'(e_bsel));
            chk(mem_dout_en == (ph == 2 || ph == 3), "R4 drive enable", 32'(mem_dout_en), 32'(ph == 2 || ph == 3));
            chk(!(mem_dout_en && !mem_oe_n), "R4 bus contention", 32'(mem_dout_en), 32'h0);
            chk(req_ready == (ph == 0), (ph == 5) ? "R8 release gap ready" : "R9 ready",
                32'(req_ready), 32'(ph == 0));
            chk(rsp_done == e_done, "R6 done pulse", 32'(rsp_done), 32'(e_done));
            if (e_done && !m_write)
                chk(rsp_rdata == e_rdata, (m_lanes == 2'b00) ? "R10 read data" : "R7 read data",
                    32'(rsp_rdata), 32'(e_rdata));
            if (act) begin
                chk(mem_addr == m_addr, "R3 address", 32'(mem_addr), 32'(m_addr));
                if (m_write) chk(mem_dout == m_data, "R3 write data", 32'(mem_dout), 32'(m_data));
            end
        end
    end

    // Issue one request; with early set the request is raised while busy and the data wiggles.
    task automatic issue(input bit w, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] l, input bit early);
        bit r;
        if (!early) begin
            @(negedge clk);
            while (!req_ready) @(negedge clk);
        end
        req_write = w; req_addr = a; req_wdata = d; req_lanes = l; req_valid = 1;
        forever begin
            r = req_ready;
            @(negedge clk);
            if (r) break;
            req_wdata = ~req_wdata;
            req_lanes = ~req_lanes;
            req_write = ~req_write;
        end
        req_valid = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_bsel_n == 2'b11 && !mem_dout_en && req_ready && !rsp_done,
            "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dout_en, req_ready, rsp_done},
            32'b1111_1010);
        issue(1, 17'h00010, 16'h1234, 2'b11, 0);   // R2 full-word write
        issue(0, 17'h00010, 16'h0000, 2'b11, 0);   // R5 full-word read
        issue(1, 17'h00010, 16'h5678, 2'b01, 0);   // R7 low lane write, right after a read (R8)
        issue(0, 17'h00010, 16'h0000, 2'b11, 0);
        issue(1, 17'h00010, 16'h9ABC, 2'b10, 0);   // R7 high lane write
        issue(0, 17'h00010, 16'h0000, 2'b01, 0);   // R7 low lane read
        issue(0, 17'h00010, 16'h0000, 2'b10, 0);   // R7 high lane read
        issue(1, 17'h1FFFF, 16'hFFFF, 2'b11, 0);   // top address
        issue(0, 17'h1FFFF, 16'h0000, 2'b11, 0);
        issue(1, 17'h00000, 16'hBEEF, 2'b00, 0);   // R10 no lanes enabled
        issue(0, 17'h00000, 16'h0000, 2'b11, 0);
        issue(0, 17'h00010, 16'h0000, 2'b00, 0);   // R10 read with no lanes
        issue(1, 17'h00020, 16'hC0DE, 2'b11, 1);   // R9 request raised while busy
        issue(0, 17'h00020, 16'h0000, 2'b11, 1);
        for (int i = 0; i < 40; i++) begin
            logic [16:0] a;
            a = 17'($urandom_range(0, 511));
            issue(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)), 1'(i % 3 == 0));
        end
        repeat (30) @(negedge clk);
        finish_run();
    end
endmodule